// File: doc/BRIEF.md
# Receive Holding Queue with Status Reporting Modes and Automatic Flow Control

This block sits between a serial deserializer and the CPU read path of an asynchronous receiver. Each completed character arrives as a byte together with three status flags: framing error, parity error and break. The block stores it in a three-entry first-in first-out queue. The deserializer's output register acts as a fourth stage. A character that completes while the queue is full waits there and moves into the queue on the next read. Any later completion before that read replaces it and raises a sticky overrun flag.

Status is reported in one of two modes. In per-character mode the three flag outputs describe only the character now at the head of the queue. In block mode each flag output is the OR of that flag over every character that has reached the head since the last clear-error command. The clear-error command also clears the overrun flag.

The block also drives a request-to-send line. Explicit commands set and clear it. When automatic control is enabled, the line is dropped if a start bit is seen while the queue is full. It is raised again once a queue position is free. A select bit chooses whether the receiver interrupt follows "queue not empty" or "queue full".

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the queue is empty, so ready, full, overrun, interrupt, request-to-send and all three status flags are 0.
- R2: Characters are read out in arrival order, and `head_data_o` shows the oldest one. Ready is 1 when at least one entry is held, and full is 1 when all three entries are held.
- R3: A character that completes while the queue is full is held outside the queue. The next read moves it in as the newest entry, so full stays 1 after that read.
- R4: A completion while the queue is full sets the overrun flag on the same clock edge. The held character is replaced by the newest one, and the three queued entries are left unchanged.
- R5: In per-character mode (`mode_block_i`=0) the status outputs equal the framing, parity and break flags of the head character, and all three are 0 when the queue is empty.
- R6: In block mode (`mode_block_i`=1) each status output is the OR of that flag over all characters that reached the head since the last clear. It changes on the edge where a character becomes head and stays set after that character is read.
- R7: The clear-error command zeroes the accumulated status and the overrun flag. A character that reaches the head on the same edge as the clear is still counted. An overrun caused on the same edge as the clear still sets the flag.
- R8: The assert command sets request-to-send and the negate command clears it. When both arrive together, negate wins.
- R9: With automatic control on, a start-bit event while full is 1 and request-to-send is 1 clears request-to-send on the next edge.
- R10: After an automatic drop, request-to-send returns to 1 on the edge after the one where full becomes 0, and not while full stays 1.
- R11: With automatic control off, a start-bit event has no effect on request-to-send.
- R12: The interrupt output equals full when `mode_irq_full_i`=1 and equals ready when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | A character has completed in the deserializer |
| rx_data_i | input | 8 | Data byte of the completed character |
| rx_fe_i | input | 1 | Framing error flag of the completed character |
| rx_pe_i | input | 1 | Parity error flag of the completed character |
| rx_brk_i | input | 1 | Break flag of the completed character |
| rx_start_i | input | 1 | A valid start bit was detected |
| cpu_pop_i | input | 1 | CPU read of the head character |
| cmd_clr_err_i | input | 1 | Clear-error command |
| cmd_rts_on_i | input | 1 | Assert request-to-send command |
| cmd_rts_off_i | input | 1 | Negate request-to-send command |
| mode_block_i | input | 1 | 1 selects block status mode, 0 selects per-character mode |
| mode_auto_rts_i | input | 1 | Enables automatic request-to-send control |
| mode_irq_full_i | input | 1 | 1 selects full as the interrupt source, 0 selects ready |
| head_data_o | output | 8 | Data byte at the head of the queue (0 when empty) |
| stat_fe_o | output | 1 | Reported framing error status |
| stat_pe_o | output | 1 | Reported parity error status |
| stat_brk_o | output | 1 | Reported break status |
| overrun_o | output | 1 | Sticky overrun flag |
| ready_o | output | 1 | Queue holds at least one character |
| full_o | output | 1 | Queue holds three characters |
| irq_o | output | 1 | Receiver interrupt request |
| rts_o | output | 1 | Request-to-send, active high |

## Verification
The queue is first filled with characters that each carry a different single flag. This shows whether the status outputs follow the head character or something else. Completions are then pushed beyond full, so that the retained fourth character can be told apart from an overwritten queue entry. The read order then shows which of the two the design kept. In block mode a clean character is placed behind flagged ones. This separates a sticky OR over characters that reached the head from a plain view of the current head. Clear commands coincide with a character reaching the head and with an overrun, which tests the priority on that edge. The request-to-send line is exercised with and without automatic control, and through a read that leaves the queue full, to show that it returns only once a position is actually free.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DATA_W = 8;

    // One received character with its status flags
    typedef struct packed {
        logic                  brk;
        logic                  pe;
        logic                  fe;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_char_t;

    typedef struct packed {
        logic brk;
        logic pe;
        logic fe;
    } rxq_flags_t;

    function automatic rxq_flags_t rxq_flags_of(input rxq_char_t c);
        rxq_flags_t f;
        f.brk = c.brk;
        f.pe  = c.pe;
        f.fe  = c.fe;
        return f;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  rxq_char_t  push_c_i,
    input  logic       pop_i,
    input  logic       clr_err_i,
    output rxq_char_t  head_c_o,
    output logic       ready_o,
    output logic       full_o,
    output logic       ovr_o,
    output logic       arrive_o,
    output rxq_flags_t arrive_f_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        rxq_char_t        hold;
        logic             hold_v;
        logic             ovr;
    } st_t;

    st_t       s_d, s_q;
    rxq_char_t mem_d [DEPTH];
    rxq_char_t mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    logic             do_pop;
    logic             enq;
    logic             push_take;
    rxq_char_t        enq_c;
    logic [CNT_W-1:0] lvl;

    always_comb begin
        s_d        = s_q;
        mem_d      = mem_q;
        do_pop     = pop_i && (s_q.cnt != '0);
        enq        = 1'b0;
        push_take  = 1'b0;
        enq_c      = '0;
        arrive_o   = 1'b0;
        arrive_f_o = '0;
        lvl        = s_q.cnt - CNT_W'(do_pop);

        if (do_pop) begin
            s_d.rd = ptr_inc(s_q.rd);
        end
        if (clr_err_i) begin
            s_d.ovr = 1'b0;
        end

        // the held character is older than any new completion
        if (s_q.hold_v && (lvl < DEPTH_C)) begin
            enq        = 1'b1;
            enq_c      = s_q.hold;
            s_d.hold_v = 1'b0;
        end else if (push_i && (lvl < DEPTH_C)) begin
            enq       = 1'b1;
            push_take = 1'b1;
            enq_c     = push_c_i;
        end

        if (enq) begin
            mem_d[s_q.wr] = enq_c;
            s_d.wr        = ptr_inc(s_q.wr);
        end

        if (push_i && !push_take) begin
            s_d.ovr    = 1'b1;
            s_d.hold   = push_c_i;
            s_d.hold_v = 1'b1;
        end

        s_d.cnt = lvl + CNT_W'(enq);

        if (do_pop && (s_q.cnt > CNT_W'(1))) begin
            arrive_o   = 1'b1;
            arrive_f_o = rxq_flags_of(mem_q[ptr_inc(s_q.rd)]);
        end else if (enq && (lvl == '0)) begin
            arrive_o   = 1'b1;
            arrive_f_o = rxq_flags_of(enq_c);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign ready_o  = (s_q.cnt != '0);
    assign full_o   = (s_q.cnt == DEPTH_C);
    assign ovr_o    = s_q.ovr;
    assign head_c_o = ready_o ? mem_q[s_q.rd] : '0;

endmodule

// File: rtl/rxq_errmode.sv
module rxq_errmode
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       block_i,
    input  logic       clr_err_i,
    input  logic       arrive_i,
    input  rxq_flags_t arrive_f_i,
    input  rxq_flags_t head_f_i,
    output rxq_flags_t flags_o
);

    rxq_flags_t acc_d, acc_q;

    always_comb begin
        acc_d = clr_err_i ? '0 : acc_q;
        if (arrive_i) begin
            acc_d = acc_d | arrive_f_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign flags_o = block_i ? acc_q : head_f_i;

endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_i,
    input  logic start_i,
    input  logic full_i,
    input  logic on_i,
    input  logic off_i,
    output logic rts_o
);

    typedef struct packed {
        logic rts;
        logic dropped;
    } rts_st_t;

    rts_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!auto_i) begin
            r_d.dropped = 1'b0;
        end else if (start_i && full_i && r_q.rts) begin
            r_d.rts     = 1'b0;
            r_d.dropped = 1'b1;
        end else if (r_q.dropped && !full_i) begin
            r_d.rts     = 1'b1;
            r_d.dropped = 1'b0;
        end
        if (on_i) begin
            r_d.rts     = 1'b1;
            r_d.dropped = 1'b0;
        end
        if (off_i) begin
            r_d.rts     = 1'b0;
            r_d.dropped = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rts_o = r_q.rts;

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_push_i,
    input  logic [RXQ_DATA_W-1:0] rx_data_i,
    input  logic                  rx_fe_i,
    input  logic                  rx_pe_i,
    input  logic                  rx_brk_i,
    input  logic                  rx_start_i,
    input  logic                  cpu_pop_i,
    input  logic                  cmd_clr_err_i,
    input  logic                  cmd_rts_on_i,
    input  logic                  cmd_rts_off_i,
    input  logic                  mode_block_i,
    input  logic                  mode_auto_rts_i,
    input  logic                  mode_irq_full_i,
    output logic [RXQ_DATA_W-1:0] head_data_o,
    output logic                  stat_fe_o,
    output logic                  stat_pe_o,
    output logic                  stat_brk_o,
    output logic                  overrun_o,
    output logic                  ready_o,
    output logic                  full_o,
    output logic                  irq_o,
    output logic                  rts_o
);

    rxq_char_t  push_c;
    rxq_char_t  head_c;
    rxq_flags_t arrive_f;
    rxq_flags_t rep_f;
    logic       arrive;

    always_comb begin
        push_c.data = rx_data_i;
        push_c.fe   = rx_fe_i;
        push_c.pe   = rx_pe_i;
        push_c.brk  = rx_brk_i;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_push_i),
        .push_c_i   (push_c),
        .pop_i      (cpu_pop_i),
        .clr_err_i  (cmd_clr_err_i),
        .head_c_o   (head_c),
        .ready_o    (ready_o),
        .full_o     (full_o),
        .ovr_o      (overrun_o),
        .arrive_o   (arrive),
        .arrive_f_o (arrive_f)
    );

    rxq_errmode u_errmode (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_i    (mode_block_i),
        .clr_err_i  (cmd_clr_err_i),
        .arrive_i   (arrive),
        .arrive_f_i (arrive_f),
        .head_f_i   (rxq_flags_of(head_c)),
        .flags_o    (rep_f)
    );

    rxq_rts u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_i  (mode_auto_rts_i),
        .start_i (rx_start_i),
        .full_i  (full_o),
        .on_i    (cmd_rts_on_i),
        .off_i   (cmd_rts_off_i),
        .rts_o   (rts_o)
    );

    assign head_data_o = head_c.data;
    assign stat_fe_o   = rep_f.fe;
    assign stat_pe_o   = rep_f.pe;
    assign stat_brk_o  = rep_f.brk;
    assign irq_o       = mode_irq_full_i ? full_o : ready_o;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_push_i,
    input logic rx_start_i,
    input logic cpu_pop_i,
    input logic cmd_clr_err_i,
    input logic cmd_rts_on_i,
    input logic cmd_rts_off_i,
    input logic mode_block_i,
    input logic mode_auto_rts_i,
    input logic stat_fe_o,
    input logic stat_pe_o,
    input logic stat_brk_o,
    input logic overrun_o,
    input logic ready_o,
    input logic full_o,
    input logic rts_o
);

    p_full_has_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> ready_o);

    p_push_full_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && full_o && !cpu_pop_i) |=> overrun_o);

    p_empty_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_block_i && !ready_o) |-> !(stat_fe_o || stat_pe_o || stat_brk_o));

    p_clear_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_err_i && !rx_push_i) |=> !overrun_o);

    p_negate_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rts_off_i |=> !rts_o);

    p_assert_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rts_on_i && !cmd_rts_off_i) |=> rts_o);

    p_auto_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_auto_rts_i && rx_start_i && full_o && !cmd_rts_on_i && !cmd_rts_off_i)
        |=> !rts_o);

    p_manual_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_auto_rts_i && !cmd_rts_on_i && !cmd_rts_off_i) |=> $stable(rts_o));

endmodule

bind rx_hold_fifo rxq_checker u_rxq_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_push_i       (rx_push_i),
    .rx_start_i      (rx_start_i),
    .cpu_pop_i       (cpu_pop_i),
    .cmd_clr_err_i   (cmd_clr_err_i),
    .cmd_rts_on_i    (cmd_rts_on_i),
    .cmd_rts_off_i   (cmd_rts_off_i),
    .mode_block_i    (mode_block_i),
    .mode_auto_rts_i (mode_auto_rts_i),
    .stat_fe_o       (stat_fe_o),
    .stat_pe_o       (stat_pe_o),
    .stat_brk_o      (stat_brk_o),
    .overrun_o       (overrun_o),
    .ready_o         (ready_o),
    .full_o          (full_o),
    .rts_o           (rts_o)
);

// File: tb/test_rx_hold_fifo.sv
module test_rx_hold_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push_i = 0, rx_fe_i = 0, rx_pe_i = 0, rx_brk_i = 0;
    logic [7:0] rx_data_i = '0;
    logic       rx_start_i = 0, cpu_pop_i = 0, cmd_clr_err_i = 0;
    logic       cmd_rts_on_i = 0, cmd_rts_off_i = 0;
    logic       mode_block_i = 0, mode_auto_rts_i = 0, mode_irq_full_i = 0;
    logic [7:0] head_data_o;
    logic       stat_fe_o, stat_pe_o, stat_brk_o, overrun_o;
    logic       ready_o, full_o, irq_o, rts_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // expected items: {brk, pe, fe, data}
    logic [10:0] exp_q[$];
    logic [10:0] hold_m;
    bit          hold_v = 0;

    always #2.5 clk = ~clk;

    rx_hold_fifo i_rx_hold_fifo (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] flags();
        return {stat_brk_o, stat_pe_o, stat_fe_o};
    endfunction

    // driver: one completed character, optionally with a clear command
    task automatic push(logic [7:0] d, logic [2:0] f, bit clr = 0);
        rx_push_i = 1; rx_data_i = d;
        {rx_brk_i, rx_pe_i, rx_fe_i} = f;
        cmd_clr_err_i = clr;
        tick();
        rx_push_i = 0; cmd_clr_err_i = 0;
        {rx_brk_i, rx_pe_i, rx_fe_i} = '0;
        if (exp_q.size() < 3) exp_q.push_back({f, d});
        else begin hold_m = {f, d}; hold_v = 1; end
    endtask

    // monitor side of the scoreboard: compare the head, then read it
    task automatic pop();
        logic [10:0] e;
        e = exp_q.pop_front();
        chk("R2 head data order", head_data_o, e[7:0]);
        if (!mode_block_i) chk("R5 head flags", flags(), e[10:8]);
        cpu_pop_i = 1;
        tick();
        cpu_pop_i = 0;
        if (hold_v) begin exp_q.push_back(hold_m); hold_v = 0; end
    endtask

    task automatic pulse_start();
        rx_start_i = 1; tick(); rx_start_i = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1
        chk("R1 ready", ready_o, 0);
        chk("R1 full", full_o, 0);
        chk("R1 overrun", overrun_o, 0);
        chk("R1 rts", rts_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 flags", flags(), 0);

        push(8'h41, 3'b001);
        chk("R2 ready one", ready_o, 1);
        chk("R2 full one", full_o, 0);
        chk("R5 head fe", flags(), 3'b001);
        mode_irq_full_i = 1; #1;
        chk("R12 irq full-select one entry", irq_o, 0);
        mode_irq_full_i = 0; #1;
        chk("R12 irq ready-select", irq_o, 1);

        push(8'h42, 3'b010);
        push(8'h43, 3'b100);
        chk("R2 full three", full_o, 1);
        chk("R5 head unchanged", flags(), 3'b001);
        mode_irq_full_i = 1; #1;
        chk("R12 irq full-select full", irq_o, 1);

        cmd_rts_on_i = 1; tick(); cmd_rts_on_i = 0;
        chk("R8 rts assert", rts_o, 1);
        mode_auto_rts_i = 1;
        pulse_start();
        chk("R9 auto drop", rts_o, 0);

        push(8'h44, 3'b000);
        chk("R4 overrun set", overrun_o, 1);
        chk("R4 entries intact", head_data_o, 8'h41);
        push(8'h45, 3'b000);

        pop();
        chk("R3 held char fills slot", full_o, 1);
        chk("R10 no early reassert", rts_o, 0);
        pop();
        chk("R2 not full", full_o, 0);
        chk("R10 one edge later", rts_o, 0);
        tick();
        chk("R10 reassert", rts_o, 1);
        pop();
        chk("R3 newest held char kept", head_data_o, 8'h45);
        pop();
        chk("R2 empty", ready_o, 0);
        chk("R5 empty flags", flags(), 0);
        chk("R12 irq empty", irq_o, 0);

        mode_auto_rts_i = 0;
        push(8'h10, 0); push(8'h11, 0); push(8'h12, 0);
        pulse_start();
        chk("R11 start ignored", rts_o, 1);
        cmd_rts_on_i = 1; cmd_rts_off_i = 1; tick();
        cmd_rts_on_i = 0; cmd_rts_off_i = 0;
        chk("R8 negate wins", rts_o, 0);
        chk("R4 overrun sticky", overrun_o, 1);
        cmd_clr_err_i = 1; tick(); cmd_clr_err_i = 0;
        chk("R7 clear overrun", overrun_o, 0);
        pop(); pop(); pop();

        mode_block_i = 1; #1;
        chk("R6 block after clear", flags(), 0);
        push(8'h20, 3'b001);
        chk("R6 first head", flags(), 3'b001);
        push(8'h21, 3'b010);
        push(8'h22, 3'b000);
        chk("R6 only head counted", flags(), 3'b001);
        pop();
        chk("R6 second head ORed", flags(), 3'b011);
        pop(); pop();
        chk("R6 sticky after drain", flags(), 3'b011);

        push(8'h23, 3'b100, 1);
        chk("R7 arrival with clear", flags(), 3'b100);
        push(8'h24, 0); push(8'h25, 0);
        push(8'h26, 0, 1);
        chk("R7 overrun beats clear", overrun_o, 1);
        chk("R7 status cleared", flags(), 3'b000);
        pop(); pop(); pop(); pop();
        chk("R3 drained", ready_o, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule